// File: doc/BRIEF.md
# Bus-Attached Serial Port with One-Byte Holding Registers

This block is a serial port that sits on an APB bus. Software writes a byte into a one-byte transmit holding register. The byte is moved into a shift engine and sent as an asynchronous frame. A separate sampling engine recovers incoming frames and leaves each byte in a one-byte receive holding register for software to read. There are no FIFOs. A byte written or received while the holder is still occupied sets a sticky overrun flag. Software clears that flag by writing a one.

The bit period is a programmable number of bus clock cycles. A divider below 16 stops all serial activity. Five interrupt lines report four conditions and their combination: a byte handed to the shifter, a byte received, transmit overrun and receive overrun. The two overrun lines follow the live overrun flags gated by their enables. A small read-only block of identification bytes sits at the top of the 4 KiB window.

Top module: `serial_port_apb`

## Requirements
- R1: Register offsets are fixed as follows: data 0x00, status 0x04, control 0x08, interrupt status 0x0C, divider 0x10. Any other offset outside the identification window reads 0, and writes to it have no effect. pready is always 1 and pslverr is always 0.
- R2: The status register layout is bit0 = transmit holder full, bit1 = receive holder full, bit2 = transmit overrun, bit3 = receive overrun. Bits 0 and 1 ignore writes. Writing a one to bit 2 or bit 3 clears that bit.
- R3: The control register keeps bits 6:0 and reads the other bits as 0. The bits are bit0 = transmit enable, bit1 = receive enable, bit2 = transmit interrupt enable, bit3 = receive interrupt enable, bit4 = transmit overrun interrupt enable, bit5 = receive overrun interrupt enable, bit6 = stored only.
- R4: Interrupt status bit2 equals status bit2 AND control bit4, and bit3 equals status bit3 AND control bit5, at all times. Bit0 is the stored transmit event and bit1 is the stored receive event. The lines irq_tx, irq_rx, irq_txovr and irq_rxovr mirror bits 0..3, and irq_any is the OR of the four bits.
- R5: Every interrupt status bit is write-one-to-clear. Writing a one to bit 2 or bit 3 also clears the matching status overrun bit.
- R6: A read of the data register returns the held received byte in bits 7:0 and clears receive-holder-full.
- R7: A frame that completes while receive is disabled is discarded. A frame that completes while the receive holder is full sets receive overrun and replaces the held byte. Every accepted byte sets receive-holder-full, and sets interrupt status bit1 when control bit3 is 1.
- R8: A data write while transmit-holder-full is set sets transmit overrun and discards the written byte. Any other data write loads the holder and sets transmit-holder-full.
- R9: When transmit is enabled, the divider is valid and the shifter is idle, a full holder is handed to the shifter and transmit-holder-full clears. If control bit2 is 1, that handoff sets interrupt status bit0.
- R10: The divider register holds 20 bits. While it is below 16, txd stays high and no handoff or reception occurs. A frame is sent LSB first as one low start bit, 8 data bits and one high stop bit, each bit lasting divider cycles.
- R11: After reset every register and both holders are 0, txd is high and all interrupt lines are low.
- R12: Twelve identification words lie at 0xFD0 + 4k for k = 0..11. Word k reads (ID_SEED + 17*k) mod 256 and ignores writes.
- R13: The receiver confirms a start bit at half a bit period after the falling edge. It rejects a low pulse that is shorter than that and delivers no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, also the serial timing base |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the 4 KiB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never signals an error |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| irq_tx | output | 1 | Transmit handoff interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit overrun interrupt |
| irq_rxovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupt lines |

## Verification
The assertions assume APB accesses in which psel is held through a two-cycle setup/access pair and paddr is stable during the access phase. They also assume that a data read never falls in the same cycle as a completed incoming frame. The bench drives every access through one task that always produces a clean setup/access sequence. It waits until each incoming frame has fully landed before it reads the data register. It always shapes rxd frames with whole bit periods aligned to the falling clock edge. The one exception is a short low pulse used to exercise start-bit rejection.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam logic [11:0] OFF_DATA = 12'h000;
  localparam logic [11:0] OFF_STAT = 12'h004;
  localparam logic [11:0] OFF_CTRL = 12'h008;
  localparam logic [11:0] OFF_ISR  = 12'h00C;
  localparam logic [11:0] OFF_DIV  = 12'h010;
  localparam int          MIN_DIV  = 16;
  localparam int          ID_WORDS = 12;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  function automatic logic div_valid(input logic [31:0] d);
    return d >= 32'(MIN_DIV);
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] k, input logic [7:0] seed);
    logic [7:0] kk;
    kk = {4'b0, k};
    return seed + kk * 8'd17;
  endfunction
endpackage

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_ok,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  input  logic [7:0]       byte_in,
  output logic             busy,
  output logic             txd
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [9:0]       frame;
  logic [3:0]       bit_idx;
  logic [DIV_W-1:0] tick;
  logic             bit_end;

  assign bit_end = (tick == div - ONE);
  assign txd     = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; frame <= '1; bit_idx <= '0; tick <= '0;
    end else if (!div_ok) begin
      busy <= 1'b0; tick <= '0;
    end else if (!busy) begin
      if (load) begin
        busy <= 1'b1; frame <= {1'b1, byte_in, 1'b0}; bit_idx <= '0; tick <= '0;
      end
    end else if (bit_end) begin
      tick  <= '0;
      frame <= {1'b1, frame[9:1]};
      if (bit_idx == 4'd9) busy <= 1'b0;
      else                 bit_idx <= bit_idx + 4'd1;
    end else begin
      tick <= tick + ONE;
    end
  end

  a_r10_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ok |=> txd);
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
  import serial_port_pkg::*;
#(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_ok,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             valid,
  output logic [7:0]       byte_out
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  rx_state_t        state;
  logic [1:0]       sync;
  logic             rxs;
  logic [DIV_W-1:0] tick;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;
  logic             half_end, bit_end;

  assign rxs      = sync[1];
  assign half_end = (tick == (div >> 1) - ONE);
  assign bit_end  = (tick == div - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b11; state <= RX_IDLE; tick <= '0; bit_idx <= '0;
      shreg <= '0; valid <= 1'b0; byte_out <= '0;
    end else begin
      sync  <= {sync[0], rxd};
      valid <= 1'b0;
      if (!div_ok) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: if (!rxs) begin state <= RX_START; tick <= '0; end
          RX_START: begin
            if (half_end) begin
              tick <= '0; bit_idx <= '0;
              state <= rxs ? RX_IDLE : RX_DATA;
            end else tick <= tick + ONE;
          end
          RX_DATA: begin
            if (bit_end) begin
              tick  <= '0;
              shreg <= {rxs, shreg[7:1]};
              if (bit_idx == 3'd7) state <= RX_STOP;
              else                 bit_idx <= bit_idx + 3'd1;
            end else tick <= tick + ONE;
          end
          default: begin
            if (bit_end) begin
              valid <= 1'b1; byte_out <= shreg; state <= RX_IDLE; tick <= '0;
            end else tick <= tick + ONE;
          end
        endcase
      end
    end
  end

  a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

// File: rtl/serial_port_apb.sv
module serial_port_apb
  import serial_port_pkg::*;
#(
  parameter int         DIV_W   = 20,
  parameter logic [7:0] ID_SEED = 8'h5A
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  input  logic        rxd,
  output logic        txd,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        irq_txovr,
  output logic        irq_rxovr,
  output logic        irq_any
);
  logic [6:0]       ctrl;
  logic [DIV_W-1:0] div;
  logic             tx_full, rx_full, st_txovr, st_rxovr, int_tx, int_rx;
  logic [7:0]       tx_buf, rx_buf, rx_byte;
  logic [3:0]       isr;
  logic             div_ok, tx_busy, rx_valid;

  // named internal events
  logic wr, rd, wr_data, wr_stat, wr_ctrl, wr_isr, wr_div, rd_data;
  logic tx_handoff, rx_take, id_hit;
  logic [3:0] id_idx;
  logic unused_bits;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign wr      = psel & penable & pwrite;
  assign rd      = psel & penable & ~pwrite;
  assign wr_data = wr && paddr == OFF_DATA;
  assign wr_stat = wr && paddr == OFF_STAT;
  assign wr_ctrl = wr && paddr == OFF_CTRL;
  assign wr_isr  = wr && paddr == OFF_ISR;
  assign wr_div  = wr && paddr == OFF_DIV;
  assign rd_data = rd && paddr == OFF_DATA;

  assign div_ok     = div_valid(32'(div));
  assign tx_handoff = tx_full && ctrl[0] && div_ok && !tx_busy;
  assign rx_take    = rx_valid && ctrl[1];

  assign id_hit = (paddr[11:6] == 6'h3F) && (paddr[5:2] >= 4'd4) && (paddr[1:0] == 2'b00);
  assign id_idx = paddr[5:2] - 4'd4;

  assign isr       = {st_rxovr & ctrl[5], st_txovr & ctrl[4], int_rx, int_tx};
  assign irq_tx    = isr[0];
  assign irq_rx    = isr[1];
  assign irq_txovr = isr[2];
  assign irq_rxovr = isr[3];
  assign irq_any   = |isr;
  assign unused_bits = ^{pwdata[31:DIV_W], ctrl[6]};

  serial_tx_shifter #(.DIV_W(DIV_W)) u_tx (
    .clk(pclk), .rst_n(presetn), .div_ok(div_ok), .div(div),
    .load(tx_handoff), .byte_in(tx_buf), .busy(tx_busy), .txd(txd));

  serial_rx_sampler #(.DIV_W(DIV_W)) u_rx (
    .clk(pclk), .rst_n(presetn), .div_ok(div_ok), .div(div),
    .rxd(rxd), .valid(rx_valid), .byte_out(rx_byte));

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      ctrl <= '0; div <= '0; tx_full <= 1'b0; rx_full <= 1'b0;
      st_txovr <= 1'b0; st_rxovr <= 1'b0; int_tx <= 1'b0; int_rx <= 1'b0;
      tx_buf <= '0; rx_buf <= '0;
    end else begin
      if (wr_ctrl) ctrl <= pwdata[6:0];
      if (wr_div)  div  <= pwdata[DIV_W-1:0];
      // transmit holder
      if (tx_handoff) tx_full <= 1'b0;
      if (wr_data && !tx_full) begin tx_full <= 1'b1; tx_buf <= pwdata[7:0]; end
      // overrun flags: clears first, events win
      if ((wr_stat || wr_isr) && pwdata[2]) st_txovr <= 1'b0;
      if ((wr_stat || wr_isr) && pwdata[3]) st_rxovr <= 1'b0;
      if (wr_data && tx_full) st_txovr <= 1'b1;
      // receive holder
      if (rd_data) rx_full <= 1'b0;
      if (rx_take) begin
        rx_full <= 1'b1; rx_buf <= rx_byte;
        if (rx_full) st_rxovr <= 1'b1;
      end
      // stored interrupt events
      if (wr_isr && pwdata[0]) int_tx <= 1'b0;
      if (wr_isr && pwdata[1]) int_rx <= 1'b0;
      if (tx_handoff && ctrl[2]) int_tx <= 1'b1;
      if (rx_take && ctrl[3])    int_rx <= 1'b1;
    end
  end

  always_comb begin
    prdata = '0;
    if (id_hit) prdata = 32'(id_byte(id_idx, ID_SEED));
    else begin
      case (paddr)
        OFF_DATA: prdata = 32'(rx_buf);
        OFF_STAT: prdata = 32'({st_rxovr, st_txovr, rx_full, tx_full});
        OFF_CTRL: prdata = 32'(ctrl);
        OFF_ISR:  prdata = 32'(isr);
        OFF_DIV:  prdata = 32'(div);
        default:  prdata = '0;
      endcase
    end
  end

  a_r8_tx_overrun: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_data && tx_full) |=> st_txovr);
  a_r9_handoff_irq: assert property (@(posedge pclk) disable iff (!presetn)
    (tx_handoff && ctrl[2]) |=> (int_tx && !tx_full));
  a_r6_read_clears: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_data && !rx_valid) |=> !rx_full);
  a_r7_drop_disabled: assert property (@(posedge pclk) disable iff (!presetn)
    (rx_valid && !ctrl[1]) |=> $stable(rx_buf));
  a_r5_isr_clears_state: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_isr && pwdata[2] && !(wr_data && tx_full)) |=> !st_txovr);
endmodule

// File: tb/serial_port_apb_test.sv
`timescale 1ns/1ps
module serial_port_apb_test;
  localparam int  DIVV = 16;
  localparam time TCK  = 20ns;
  localparam time BIT  = DIVV * TCK;

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0, rxd = 1;
  logic [11:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, pslverr, txd, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

  int n_run = 0, n_fail = 0, frames = 0;
  logic [7:0] txq[$];

  always #(TCK/2) pclk = ~pclk;

  serial_port_apb uut (.pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_txovr(irq_txovr), .irq_rxovr(irq_rxovr), .irq_any(irq_any));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1; d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  // driver: queue the expected byte, then write it
  task automatic send_tx(input logic [7:0] b);
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_rd(12'h004, s);
      if (s[0] == 1'b0) break;
    end
    txq.push_back(b);
    bus_wr(12'h000, 32'(b));
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge pclk);
    rxd = 0; #(BIT);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; #(BIT); end
    rxd = 1; #(BIT);
  endtask

  // monitor: decode txd frames, pop and compare
  initial begin
    wait (presetn);
    forever begin
      logic [7:0] got, exp;
      @(negedge txd);
      #(BIT/2 + 5ns);
      check("R10 start bit low", 32'(txd), 32'h0);
      for (int i = 0; i < 8; i++) begin #(BIT); got[i] = txd; end
      #(BIT);
      check("R10 stop bit high", 32'(txd), 32'h1);
      frames++;
      if (txq.size() == 0) check("R10 unexpected frame", 32'(got), 32'hFFFF_FFFF);
      else begin exp = txq.pop_front(); check("R10 frame byte", 32'(got), 32'(exp)); end
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge pclk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int f0;
    repeat (5) @(negedge pclk);
    presetn = 1;
    // R11 reset state, R1 handshake
    expect_rd("R11 status", 12'h004, 0);
    expect_rd("R11 ctrl", 12'h008, 0);
    expect_rd("R11 isr", 12'h00C, 0);
    expect_rd("R11 div", 12'h010, 0);
    expect_rd("R11 data", 12'h000, 0);
    check("R11 txd idle", 32'(txd), 1);
    check("R11 irq_any", 32'(irq_any), 0);
    check("R1 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    // R10 divider width
    bus_wr(12'h010, 32'hFFFF_FFFF);
    expect_rd("R10 div 20 bits", 12'h010, 32'h000F_FFFF);
    bus_wr(12'h010, DIVV);
    // R3 control width
    bus_wr(12'h008, 32'hFF);
    expect_rd("R3 ctrl 7 bits", 12'h008, 32'h7F);
    bus_wr(12'h008, 32'h04);
    // R1 unmapped
    bus_wr(12'h020, 32'h1234);
    expect_rd("R1 unmapped 0x20", 12'h020, 0);
    expect_rd("R1 unmapped 0x14", 12'h014, 0);
    // R12 identification
    expect_rd("R12 id k0", 12'hFD0, 32'h5A);
    expect_rd("R12 id k4", 12'hFE0, 32'h9E);
    expect_rd("R12 id k11", 12'hFFC, 32'h15);
    bus_wr(12'hFD0, 32'h0);
    expect_rd("R12 id write ignored", 12'hFD0, 32'h5A);
    // R8 holder and overrun, tx disabled
    bus_wr(12'h000, 32'hA5);
    expect_rd("R8 full set", 12'h004, 32'h1);
    bus_wr(12'h000, 32'h3C);
    expect_rd("R8 overrun", 12'h004, 32'h5);
    expect_rd("R4 overrun gated off", 12'h00C, 0);
    // R4 live overrun interrupt
    bus_wr(12'h008, 32'h14);
    expect_rd("R4 isr overrun", 12'h00C, 32'h4);
    check("R4 irq_txovr/any", {30'b0, irq_txovr, irq_any}, 32'h3);
    // R2 read-only full bit
    bus_wr(12'h004, 32'h1);
    expect_rd("R2 full bit read-only", 12'h004, 32'h5);
    // R5 isr clear also clears status
    bus_wr(12'h00C, 32'h4);
    expect_rd("R5 status overrun cleared", 12'h004, 32'h1);
    expect_rd("R5 isr cleared", 12'h00C, 0);
    check("R5 irq_any low", 32'(irq_any), 0);
    // R9 handoff (first byte kept, overrun byte discarded per R8)
    txq.push_back(8'hA5);
    bus_wr(12'h008, 32'h15);
    expect_rd("R9 isr tx event", 12'h00C, 32'h1);
    check("R9 irq_tx", 32'(irq_tx), 1);
    expect_rd("R9 holder empty", 12'h004, 32'h0);
    bus_wr(12'h00C, 32'h1);
    expect_rd("R5 tx event cleared", 12'h00C, 0);
    // R10 patterns
    send_tx(8'h5A); send_tx(8'h00); send_tx(8'hFF); send_tx(8'h81);
    for (int i = 0; i < 3000 && txq.size() != 0; i++) @(negedge pclk);
    repeat (2 * DIVV) @(negedge pclk);
    check("R10 five frames", 32'(frames), 5);
    // R10 invalid divider blocks activity
    f0 = frames;
    bus_wr(12'h010, 8);
    txq.push_back(8'h77);
    bus_wr(12'h000, 32'h77);
    repeat (500) @(negedge pclk);
    check("R10 no frame while invalid", 32'(frames), 32'(f0));
    check("R10 txd high while invalid", 32'(txd), 1);
    expect_rd("R10 holder stays full", 12'h004, 32'h1);
    bus_wr(12'h010, DIVV);
    repeat (14 * DIVV) @(negedge pclk);
    check("R10 frame after valid div", 32'(frames), 32'(f0 + 1));
    check("R10 queue drained", 32'(txq.size()), 0);
    bus_wr(12'h00C, 32'hF);
    // R7 discard while receive disabled
    bus_wr(12'h008, 32'h01);
    send_rx(8'h33);
    repeat (20) @(negedge pclk);
    expect_rd("R7 disabled discards", 12'h004, 0);
    // R6 receive and read
    bus_wr(12'h008, 32'h0B);
    send_rx(8'hC3);
    repeat (20) @(negedge pclk);
    expect_rd("R7 rx full", 12'h004, 32'h2);
    expect_rd("R7 isr rx event", 12'h00C, 32'h2);
    check("R7 irq_rx", 32'(irq_rx), 1);
    expect_rd("R6 data byte", 12'h000, 32'hC3);
    expect_rd("R6 full cleared", 12'h004, 0);
    // R7 overrun replaces
    send_rx(8'h11);
    send_rx(8'h22);
    repeat (20) @(negedge pclk);
    expect_rd("R7 rx overrun", 12'h004, 32'hA);
    bus_wr(12'h008, 32'h2B);
    expect_rd("R4 rx overrun isr", 12'h00C, 32'hA);
    check("R4 irq_rxovr", 32'(irq_rxovr), 1);
    bus_wr(12'h004, 32'h2);
    expect_rd("R2 rx full read-only", 12'h004, 32'hA);
    expect_rd("R7 newest byte kept", 12'h000, 32'h22);
    bus_wr(12'h004, 32'h8);
    expect_rd("R2 w1c rx overrun", 12'h004, 0);
    expect_rd("R4 rx overrun isr follows", 12'h00C, 32'h2);
    // R13 short low pulse rejected
    bus_wr(12'h00C, 32'hF);
    @(negedge pclk); rxd = 0;
    repeat (3) @(negedge pclk); rxd = 1;
    repeat (400) @(negedge pclk);
    expect_rd("R13 glitch rejected", 12'h004, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule